// File: doc/BRIEF.md
# Triggered Clock Source Selector

This block picks one of several parent clock-enable inputs and forwards it, optionally thinned by a pre-divider, as a single clock-enable output. Software writes a 32-bit configuration word that holds a selector code field and a pre-divider field. Nothing in that word takes effect until a separate trigger strobe commits it. While the commit is in progress the block reports busy, and software polls busy until it reads zero.

Selector codes are sparse: the field can hold more values than there are parents, and a parameter table maps each defined code to a parent index. The code loaded at reset can be one that maps to no parent. In that case the output stays quiet and an invalid-source flag is raised until a valid commit. A commit of an undefined code is refused: the previous selection and divisor stay in force and busy drops after one cycle. An accepted switch holds the output low for one full cycle before the new parent drives it, so the old and new enables can never merge into a glitch.

Top module: `clk_src_select`

## Requirements
- R1: After reset the configuration word reads with the selector field (bits 6:4) equal to the reset code 7 and all other bits zero, `invalid_src` is 1, `busy` is 0 and `clk_en_o` is 0 even with every parent enable high.
- R2: The selector field sits at bits 6:4 and the pre-divider field at bits 15:12 of the configuration word. Codes 1, 2, 4 and 6 map to parents 0, 1, 2 and 3; codes 0, 3, 5 and 7 map to no parent.
- R3: While the active code maps to no parent, `invalid_src` is 1 and `clk_en_o` stays 0.
- R4: A `trig_set` pulse sampled while `gate_on` is 1 and `busy` is 0 is accepted, and `busy` is 1 from the next cycle. The commit uses the configuration word as held in that cycle.
- R5: An accepted commit of a defined code holds `busy` for exactly two cycles. In the first of those cycles `clk_en_o` is 0, and from the second the new parent drives the output and `cur_idx` shows it.
- R6: An accepted commit of an undefined code leaves the selection, `invalid_src` and the divisor unchanged and holds `busy` for exactly one cycle.
- R7: A `trig_set` pulse while `gate_on` is 0, or while `busy` is 1, is ignored: no busy cycle is added and the selection does not change.
- R8: The pre-divider field stores the divisor minus one. With divisor field n, `clk_en_o` passes one out of every n+1 enables of the selected parent. The counter restarts at each accepted switch, and a written divisor takes effect only through a commit.
- R9: `cfg_rdata` returns the full 32-bit word last written, including writes made while busy. Such a write becomes the pending value for the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_en_i | input | NPAR (4) | Clock-enable of each parent, indexed by parent number |
| gate_on | input | 1 | High when the downstream clock gate is enabled; commits need it |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| trig_set | input | 1 | Write of 1 to the trigger; requests a commit |
| busy | output | 1 | Trigger readback: 1 while a commit is in progress |
| clk_en_o | output | 1 | Selected and pre-divided clock enable |
| invalid_src | output | 1 | Active selector code maps to no parent |
| cur_idx | output | IW (2) | Index of the parent currently in force |

## Verification
The bench goes after the reset code that matches no parent. A design that decoded it as parent 0 would drive `clk_en_o` right after reset instead of flagging the source as invalid. It commits undefined codes and checks that a design which wrongly applied them would lose its selection or divisor, or hold busy for the wrong number of cycles. It also measures the busy length and the blank cycle on every switch, because a design that skipped the blank would pass the old enable into the first cycle of the new source. Triggers fired with the gate off or during a commit must leave no trace. A design that queued them would add busy cycles or apply the word written in mid-commit.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Commit sequencer states
  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,  // no commit in progress
    CS_BLANK  = 2'd1,  // output held low, new selection loading
    CS_SETTLE = 2'd2,  // new source active, busy still reported
    CS_REJECT = 2'd3   // undefined code refused, one busy cycle
  } csel_state_e;

endpackage

// File: rtl/csel_decode.sv
module csel_decode #(
  parameter int unsigned NPAR = 4,
  parameter int unsigned SW   = 3,
  parameter logic [NPAR*SW-1:0] MAP = '0,
  localparam int unsigned IW = (NPAR > 1) ? $clog2(NPAR) : 1
) (
  input  logic [SW-1:0] code,
  output logic          hit,
  output logic [IW-1:0] idx
);

  logic [NPAR-1:0] match;

  // One comparator per parent slot
  for (genvar p = 0; p < NPAR; p++) begin : g_cmp
    assign match[p] = (code == MAP[p*SW +: SW]);
  end

  always_comb begin
    idx = '0;
    for (int p = 0; p < NPAR; p++) begin
      if (match[p]) idx = IW'(p);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/csel_commit.sv
module csel_commit
  import csel_pkg::*;
#(
  parameter int unsigned IW        = 2,
  parameter int unsigned DW        = 4,
  parameter logic        RST_VALID = 1'b0,
  parameter logic [IW-1:0] RST_IDX = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_req,
  input  logic          gate_on,
  input  logic          pend_hit,
  input  logic [IW-1:0] pend_idx,
  input  logic [DW-1:0] pend_div,
  output logic          busy,
  output logic          blank,
  output logic          act_valid,
  output logic [IW-1:0] act_idx,
  output logic [DW-1:0] act_div
);

  csel_state_e state_q, state_d;
  logic          accept;
  logic          hold_en;
  logic          act_en;
  logic [IW-1:0] hold_idx_q;
  logic [DW-1:0] hold_div_q;

  assign accept  = trig_req & gate_on & (state_q == CS_IDLE);
  assign hold_en = accept & pend_hit;
  assign act_en  = (state_q == CS_BLANK);

  always_comb begin
    state_d = state_q;
    case (state_q)
      CS_IDLE:   if (accept) state_d = pend_hit ? CS_BLANK : CS_REJECT;
      CS_BLANK:  state_d = CS_SETTLE;
      CS_SETTLE: state_d = CS_IDLE;
      CS_REJECT: state_d = CS_IDLE;
      default:   state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_IDLE;
    else        state_q <= state_d;
  end

  // Captured target, loaded only when a defined code is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_idx_q <= '0;
      hold_div_q <= '0;
    end else if (hold_en) begin
      hold_idx_q <= pend_idx;
      hold_div_q <= pend_div;
    end
  end

  // Selection in force, swapped at the end of the blank cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= RST_VALID;
      act_idx   <= RST_IDX;
      act_div   <= '0;
    end else if (act_en) begin
      act_valid <= 1'b1;
      act_idx   <= hold_idx_q;
      act_div   <= hold_div_q;
    end
  end

  assign busy  = (state_q != CS_IDLE);
  assign blank = (state_q == CS_BLANK);

endmodule

// File: rtl/csel_prediv.sv
module csel_prediv #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_en,
  input  logic          clr,
  input  logic [DW-1:0] div,
  output logic          out_en
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (in_en) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign out_en = in_en & wrap;

endmodule

// File: rtl/clk_src_select.sv
module clk_src_select #(
  parameter int unsigned NPAR       = 4,
  parameter int unsigned SW         = 3,
  parameter int unsigned SEL_SHIFT  = 4,
  parameter int unsigned DW         = 4,
  parameter int unsigned DIV_SHIFT  = 12,
  parameter bit          HAS_PREDIV = 1'b1,
  parameter int unsigned RESET_CODE = 7,
  parameter logic [NPAR*SW-1:0] MAP = {3'd6, 3'd4, 3'd2, 3'd1},
  localparam int unsigned IW = (NPAR > 1) ? $clog2(NPAR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPAR-1:0] src_en_i,
  input  logic            gate_on,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            trig_set,
  output logic            busy,
  output logic            clk_en_o,
  output logic            invalid_src,
  output logic [IW-1:0]   cur_idx
);

  // Constant lookup used only to derive reset values
  function automatic logic [IW:0] map_lookup(input logic [SW-1:0] c);
    logic [IW:0] r;
    r = '0;
    for (int p = 0; p < NPAR; p++) begin
      if (MAP[p*SW +: SW] == c) r = {1'b1, IW'(p)};
    end
    return r;
  endfunction

  localparam logic [SW-1:0]  RST_CODE  = SW'(RESET_CODE);
  localparam logic [IW:0]    RST_LK    = map_lookup(RST_CODE);
  localparam logic [31:0]    RST_WORD  = 32'(RST_CODE) << SEL_SHIFT;

  logic [31:0]   cfg_q;
  logic [SW-1:0] pend_code;
  logic [DW-1:0] pend_div;
  logic          pend_hit;
  logic [IW-1:0] pend_idx;
  logic          blank;
  logic          act_valid;
  logic [IW-1:0] act_idx;
  logic [DW-1:0] act_div;
  logic          sel_en;

  // Configuration word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_WORD;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign cfg_rdata = cfg_q;
  assign pend_code = cfg_q[SEL_SHIFT +: SW];
  assign pend_div  = cfg_q[DIV_SHIFT +: DW];

  csel_decode #(
    .NPAR (NPAR),
    .SW   (SW),
    .MAP  (MAP)
  ) u_dec (
    .code (pend_code),
    .hit  (pend_hit),
    .idx  (pend_idx)
  );

  csel_commit #(
    .IW        (IW),
    .DW        (DW),
    .RST_VALID (RST_LK[IW]),
    .RST_IDX   (RST_LK[IW-1:0])
  ) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_req  (trig_set),
    .gate_on   (gate_on),
    .pend_hit  (pend_hit),
    .pend_idx  (pend_idx),
    .pend_div  (pend_div),
    .busy      (busy),
    .blank     (blank),
    .act_valid (act_valid),
    .act_idx   (act_idx),
    .act_div   (act_div)
  );

  assign sel_en = act_valid & ~blank & src_en_i[act_idx];

  if (HAS_PREDIV) begin : g_prediv
    csel_prediv #(
      .DW (DW)
    ) u_prediv (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_en  (sel_en),
      .clr    (blank),
      .div    (act_div),
      .out_en (clk_en_o)
    );
  end else begin : g_direct
    assign clk_en_o = sel_en;
  end

  assign invalid_src = ~act_valid;
  assign cur_idx     = act_idx;

endmodule

// File: rtl/clk_src_select_chk.sv
module clk_src_select_chk #(
  parameter int unsigned IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_set,
  input logic          gate_on,
  input logic          busy,
  input logic          clk_en_o,
  input logic          invalid_src,
  input logic [IW-1:0] cur_idx
);

  assert_invalid_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_src |-> !clk_en_o);

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_set && gate_on && !busy) |=> busy);

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  assert_blank_before_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> !$past(clk_en_o));

  assert_gate_off_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_set && !gate_on && !busy) |=> (!busy && $stable(cur_idx)));

endmodule

bind clk_src_select clk_src_select_chk #(.IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_set    (trig_set),
  .gate_on     (gate_on),
  .busy        (busy),
  .clk_en_o    (clk_en_o),
  .invalid_src (invalid_src),
  .cur_idx     (cur_idx)
);

// File: tb/clk_src_select_test.sv
module clk_src_select_test;

  logic        clk;
  logic        rst_n;
  logic [3:0]  src_en_i;
  logic        gate_on;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        trig_set;
  logic        busy;
  logic        clk_en_o;
  logic        invalid_src;
  logic [1:0]  cur_idx;

  int checks;
  int failures;
  bit done;

  clk_src_select uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_en_i    (src_en_i),
    .gate_on     (gate_on),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .trig_set    (trig_set),
    .busy        (busy),
    .clk_en_o    (clk_en_o),
    .invalid_src (invalid_src),
    .cur_idx     (cur_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {gate, code, div field, exp idx, exp div, exp busy cycles}
  localparam logic [15:0] VEC [9] = '{
    {1'b1, 3'd2, 4'd1, 2'd1, 4'd1, 2'd2},
    {1'b1, 3'd3, 4'd5, 2'd1, 4'd1, 2'd1},
    {1'b0, 3'd4, 4'd2, 2'd1, 4'd1, 2'd0},
    {1'b1, 3'd4, 4'd2, 2'd2, 4'd2, 2'd2},
    {1'b1, 3'd1, 4'd0, 2'd0, 4'd0, 2'd2},
    {1'b1, 3'd6, 4'd3, 2'd3, 4'd3, 2'd2},
    {1'b1, 3'd0, 4'd4, 2'd3, 4'd3, 2'd1},
    {1'b1, 3'd7, 4'd2, 2'd3, 4'd3, 2'd1},
    {1'b1, 3'd6, 4'd5, 2'd3, 4'd5, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Pulse trigger; returns busy cycles and output level in the first cycle
  task automatic fire(output int blen, output logic first_out);
    @(negedge clk);
    trig_set = 1'b1;
    @(negedge clk);
    trig_set = 1'b0;
    first_out = clk_en_o;
    blen = 0;
    while (busy && blen < 6) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic count_pulses(input int idx, output int n);
    src_en_i = 4'(1 << idx);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (clk_en_o) n++;
    end
    src_en_i = 4'hF;
  endtask

  initial begin
    int   blen;
    int   np;
    logic fo;
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; src_en_i = 4'hF; gate_on = 1'b1;
    cfg_we = 1'b0; cfg_wdata = '0; trig_set = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cfg_rdata == 32'h0000_0070, "R1", "reset word", cfg_rdata, 32'h70);
    chk(invalid_src == 1'b1, "R1", "invalid after reset", invalid_src, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    np = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (clk_en_o) np++;
    end
    chk(np == 0, "R1", "output quiet after reset (R3)", np, 0);

    // R6 commit of the undefined reset code
    fire(blen, fo);
    chk(blen == 1, "R6", "busy length on reset code", blen, 1);
    chk(invalid_src == 1'b1, "R3", "still invalid", invalid_src, 1);

    // Vector walk (R2, R4, R5, R6, R7, R8, R9)
    for (int v = 0; v < 9; v++) begin
      logic [15:0] e;
      logic [31:0] w;
      e = VEC[v];
      w = 32'hA000_0000 | (32'(e[11:8]) << 12) | (32'(e[14:12]) << 4);
      write_cfg(w);
      chk(cfg_rdata == w, "R9", "readback", cfg_rdata, w);
      gate_on = e[15];
      src_en_i = 4'hF;
      fire(blen, fo);
      gate_on = 1'b1;
      chk(blen == int'(e[1:0]), "R4", "busy length", blen, e[1:0]);
      if (e[1:0] == 2'd2)
        chk(fo == 1'b0, "R5", "blank cycle", fo, 0);
      chk(cur_idx == e[7:6], "R2", "selected parent", cur_idx, e[7:6]);
      chk(invalid_src == 1'b0, "R3", "valid source", invalid_src, 0);
      count_pulses(int'(e[7:6]), np);
      chk(np == 12 / (int'(e[5:2]) + 1), "R8", "pulses per 12", np,
          12 / (int'(e[5:2]) + 1));
    end

    // R7 trigger while busy is dropped; R9 write during busy becomes pending
    write_cfg(32'h0000_0010);
    @(negedge clk);
    trig_set = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_2040;
    @(negedge clk);
    trig_set = 1'b0; cfg_we = 1'b0;
    blen = 0;
    while (busy && blen < 6) begin
      blen++;
      @(negedge clk);
    end
    chk(cur_idx == 2'd0, "R7", "second trigger ignored", cur_idx, 0);
    chk(cfg_rdata == 32'h0000_2040, "R9", "write during busy kept", cfg_rdata, 32'h2040);
    count_pulses(0, np);
    chk(np == 12, "R8", "divisor not applied before commit", np, 12);
    fire(blen, fo);
    chk(blen == 2, "R5", "pending commit busy length", blen, 2);
    chk(cur_idx == 2'd2, "R9", "pending word committed", cur_idx, 2);
    count_pulses(2, np);
    chk(np == 4, "R8", "divide by three", np, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule